// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Divider

The block takes a free-running reference clock and drives a single output clock at the full reference rate or at one half, one quarter or one eighth of it. The rate is picked by a two-bit select whose codes are not in binary order. The select may change while the output is running. The new rate takes hold only at an instant when every candidate output is low, so no shortened high or low pulse ever reaches the output.

An enable input, driven by an external activation sequencer, decides when the clock may appear at the output. The enable is synchronised into the reference domain and applied at the same safe instant as a rate change. The output therefore starts with a complete low phase and a complete first pulse, and it stops after a complete last pulse. When the block is not running, the output is held low.

A three-bit tick counter runs on every rising reference edge. The divided clocks are its registered bits, which gives an exact 50% duty. The undivided clock is the reference itself, gated by a flop that changes only on falling reference edges.

Top module: `clk_ratio_gen`

## Requirements
- R1: A synchronous active-low reset, sampled on a rising reference edge, clears the tick counter and the running state. It selects divide-by-8 as the current rate. From the first falling reference edge inside reset onward, the output is low.
- R2: The select codes `ratio_sel[1:0]` map to rates as follows: 2'b00 gives divide-by-8, 2'b01 gives divide-by-4, 2'b11 gives divide-by-2 and 2'b10 gives the undivided reference. A divided output is high for exactly half its period and low for the other half, with each transition on a rising reference edge.
- R3: With the undivided code applied and the block running, the output is high exactly while the reference is high.
- R4: The select is sampled only on the rising reference edge where the tick counter goes from 7 to 0. Select values that come and go between two such edges have no effect on the output.
- R5: On the rising edge where the counter wraps, every divided output is low. No high or low output pulse is ever shorter than half a reference period.
- R6: On any rate change, the last pulse at the old rate and the first pulse at the new rate each have the full width for their own rate.
- R7: The enable passes through a synchroniser of `SYNC_STAGES` flops. The running state takes the synchronised enable only on the counter wrap edge, so starting and stopping never truncate a pulse.
- R8: While the block is not running, the output stays low for every select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_sel | input | 2 | Rate select code |
| clk_en | input | 1 | Asynchronous enable from the activation sequencer |
| clk_out | output | 1 | Divided or gated output clock |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. With that value, the enable latency of two synchroniser edges plus up to eight counter edges fits inside short observation windows. A reference model predicts the output in both phases of every reference period. Every output pulse width is measured directly. Rising edges are counted over 32-period windows, which confirms each rate after full-to-divided, divided-to-full and divided-to-divided switches. The same windows confirm that a select pulse lying between wrap edges, and any select change while stopped, leave the output unchanged.

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       clk_en,
  output logic       clk_out
);

  logic [SYNC_STAGES-1:0] en_pipe;
  logic [2:0] tick;
  logic [1:0] stage_q;
  logic       run_q;
  logic       div_q;
  logic       full_gate;

  wire       wrap   = (tick == 3'b111);
  wire [2:0] tick_n = tick + 3'd1;

  function automatic logic [1:0] to_stage(input logic [1:0] s);
    case (s)
      2'b00:   return 2'd3;
      2'b01:   return 2'd2;
      2'b11:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic pick(input logic [2:0] t, input logic [1:0] st);
    case (st)
      2'd1:    return t[0];
      2'd2:    return t[1];
      2'd3:    return t[2];
      default: return 1'b0;
    endcase
  endfunction

  logic [1:0] stage_n;
  logic       run_n;
  assign stage_n = wrap ? to_stage(ratio_sel) : stage_q;
  assign run_n   = wrap ? en_pipe[SYNC_STAGES-1] : run_q;

  always_ff @(posedge ref_clk) begin
    if (!rst_n) begin
      en_pipe <= '0;
      tick    <= '0;
      stage_q <= 2'd3;
      run_q   <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      en_pipe <= {en_pipe[SYNC_STAGES-2:0], clk_en};
      tick    <= tick_n;
      stage_q <= stage_n;
      run_q   <= run_n;
      div_q   <= run_n && pick(tick_n, stage_n);
    end
  end

  always_ff @(negedge ref_clk) begin
    if (!rst_n) full_gate <= 1'b0;
    else        full_gate <= run_q && (stage_q == 2'd0);
  end

  assign clk_out = div_q | (ref_clk & full_gate);

endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       clk_out,
  input logic [2:0] tick,
  input logic [1:0] stage_q,
  input logic       run_q,
  input logic       div_q,
  input logic       full_gate
);

  assert_reset_clear_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(!rst_n) |-> (tick == 3'd0 && !run_q && stage_q == 2'd3 && !clk_out));

  assert_half_toggle_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (run_q && stage_q == 2'd1 && $past(run_q && stage_q == 2'd1)) |-> (div_q != $past(div_q)));

  assert_ratio_hold_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (tick != 3'b111) |=> $stable(stage_q));

  assert_wrap_low_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (tick == 3'b111) |=> !div_q);

  assert_run_hold_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (tick != 3'b111) |=> $stable(run_q));

  assert_idle_low_R8: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (!run_q && !full_gate) |-> !clk_out);

endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .clk_out  (clk_out),
  .tick     (tick),
  .stage_q  (stage_q),
  .run_q    (run_q),
  .div_q    (div_q),
  .full_gate(full_gate)
);

// File: tb/clk_ratio_gen_bench.sv
`timescale 1ns/1ps
module clk_ratio_gen_bench;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic en = 1'b0;
  logic clk_out;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  bit done = 0;
  bit mon_on = 0;
  string cur_req = "R1";

  clk_ratio_gen #(.SYNC_STAGES(SYNC)) u_clk_ratio_gen (
    .ref_clk(clk), .rst_n(rst_n), .ratio_sel(sel), .clk_en(en), .clk_out(clk_out));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int log_ratio(input logic [1:0] s);
    if (s == 2'b00) return 3;
    if (s == 2'b01) return 2;
    if (s == 2'b11) return 1;
    return 0;
  endfunction

  // reference model
  int m_cnt = 0, m_k = 3;
  bit m_run = 0, m_div = 0, m_gate = 0;
  bit enq[$];

  always @(posedge clk) begin
    bit used;
    if (!rst_n) begin
      m_cnt = 0; m_k = 3; m_run = 0; m_div = 0;
      enq.delete();
    end else begin
      used = (enq.size() >= SYNC) ? enq[enq.size() - SYNC] : 1'b0;
      enq.push_back(en);
      if (enq.size() > 16) void'(enq.pop_front());
      if (m_cnt == 7) begin
        m_k = log_ratio(sel);
        m_run = used;
      end
      m_cnt = (m_cnt + 1) % 8;
      m_div = m_run && (m_k != 0) && (((m_cnt >> (m_k - 1)) & 1) == 1);
    end
  end

  always @(negedge clk) m_gate = rst_n ? (m_run && m_k == 0) : 1'b0;

  always begin
    @(negedge clk); #5;
    chk(clk_out == m_div, cur_req, clk_out, m_div);
    @(posedge clk); #5;
    chk(clk_out == (m_div | m_gate), cur_req, clk_out, m_div | m_gate);
  end

  always @(posedge clk_out) rises++;

  realtime last_t = 0.0;
  always @(clk_out) begin
    if (mon_on) begin
      chk(($realtime - last_t) >= 9.0, "R5 pulse width", int'($realtime - last_t), 10);
    end
    last_t = $realtime;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic window(input int n, input int exp, input string req);
    int r0;
    r0 = rises;
    cycles(n);
    chk(rises - r0 == exp, req, rises - r0, exp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cycles(4);
    chk(clk_out == 1'b0, "R1 reset low", clk_out, 0);
    rst_n = 1'b1;
    last_t = $realtime; mon_on = 1;
    en = 1'b1; sel = 2'b00; cur_req = "R2";
    cycles(30); window(32, 4, "R2 div8");
    sel = 2'b01; cycles(20); window(32, 8, "R2 div4");
    sel = 2'b11; cycles(20); window(32, 16, "R2 div2");
    cur_req = "R3";
    sel = 2'b10; cycles(20); window(32, 32, "R3 full");
    cur_req = "R6";
    sel = 2'b00; cycles(20); window(32, 4, "R6 full to div8");
    sel = 2'b10; cycles(20); window(32, 32, "R6 div8 to full");
    sel = 2'b01; cycles(20); window(32, 8, "R6 full to div4");
    cur_req = "R4";
    while (m_cnt != 1) @(negedge clk);
    #2 sel = 2'b11;
    cycles(3);
    sel = 2'b01;
    window(32, 8, "R4 ignored select pulse");
    cur_req = "R7";
    en = 1'b0; cycles(16);
    cur_req = "R8";
    begin
      int r0;
      r0 = rises;
      for (int i = 0; i < 8; i++) begin
        sel = 2'(i);
        cycles(4);
      end
      chk(rises - r0 == 0, "R8 idle low", rises - r0, 0);
    end
    cur_req = "R7";
    sel = 2'b10; en = 1'b1;
    cycles(20); window(32, 32, "R7 restart full");
    cur_req = "R1";
    rst_n = 1'b0; cycles(2);
    @(posedge clk); #5;
    chk(clk_out == 1'b0, "R1 mid-run reset", clk_out, 0);
    cycles(1);
    rst_n = 1'b1; sel = 2'b11; cur_req = "R2";
    cycles(20); window(32, 16, "R2 after reset div2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule